// File: doc/BRIEF.md
# RTC Calendar Alarm Comparator

This block holds the alarm settings of a real-time clock: one register each for seconds, minutes, hours, weekday, date and month. Each register holds a BCD value and its own enable bit. Every clock cycle the block samples the BCD counter values from the clock's counter chain into a register. It compares each enabled alarm field with its sampled counter. When all enabled fields agree, the combined match is true. When the combined match turns from false to true, a sticky alarm flag is set. A separate interrupt-enable bit passes that flag to the interrupt output.

Software programs the block through a plain register bus. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The bus carries no streaming data, so it has no valid/ready handshake and no back-pressure: every write is accepted in its cycle. There are two resets. Power-on reset clears the enable bits and the control state. Manual reset clears only the control state. Neither reset touches the stored BCD values. The counter chain, leap-year handling and range checks on written values belong elsewhere. A value outside a field's valid range gives undefined alarm behaviour.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After power-on reset, bit 7 of every alarm register reads 0, the control register at address 6 reads 8'h00, and `irq` is 0.
- R2: Addresses 0 to 5 select the seconds, minutes, hours, weekday, date and month alarms. Bit 7 of each is the enable bit. The writable value bits are 6:0 for seconds and minutes, 5:0 for hours and date, 2:0 for weekday, and 4:0 for month. Writes to any other bit have no effect, and those bits read back as 0.
- R3: A field whose enable bit is 0 does not take part in the comparison, whatever its counter value. An enabled field compares only its writable value bits with the same bits of its 7-bit counter input.
- R4: When every enabled field equals its counter, the alarm flag (control bit 0) is set. A counter change applied before clock edge N shows in the flag after edge N+1, and not after edge N.
- R5: When no enable bit is set, the flag is never set, even if all counters equal the alarm values.
- R6: The flag is set only when the combined match goes from false to true. If the flag is cleared while the match stays true, it is not set again until the match has gone false and then true.
- R7: Writing 0 to control bit 0 clears the flag, and writing 1 to it has no effect. If a clear and a new match edge happen in the same cycle, the flag ends up set.
- R8: Control bit 1 is the interrupt enable, and `irq` equals flag AND interrupt enable. The flag is still recorded while the interrupt enable is 0.
- R9: Manual reset clears the flag and the interrupt enable. It keeps every enable bit and every stored alarm value.
- R10: Power-on reset clears all enable bits and keeps the stored alarm values, which read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus, counter sampling and flag logic |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| mrst_n | input | 1 | Active-low asynchronous manual reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 to 5 alarms, 6 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| cnt_bcd | input | 42 | Counter chain values, 7 bits per field, seconds in bits 6:0 and month in bits 41:35 |
| irq | output | 1 | Alarm interrupt request |

## Verification
Some properties hold on every cycle, so the assertions check them continuously. A rising flag must be preceded by a fresh match edge and by at least one enabled field. The flag may only drop after a clearing write. `irq` is never high without the interrupt enable. Reserved month bits always read as zero. Enable bits hold steady through a manual reset. Other behaviour needs the bench's scenarios to show it: which combinations of enables and counter values produce an alarm, the exact two-edge latency, the outcome when a set and a clear collide, and how stored values survive each kind of reset.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD = 6;
  localparam int VW     = 7;
  localparam int RW     = VW + 1;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_WDAY = 3'd3,
    SEL_DATE = 3'd4,
    SEL_MON  = 3'd5,
    SEL_CTRL = 3'd6
  } reg_sel_e;

  // writable value bits of each alarm field
  function automatic logic [VW-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 7'h7F;
      2, 4:    field_mask = 7'h3F;
      3:       field_mask = 7'h07;
      5:       field_mask = 7'h1F;
      default: field_mask = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field #(
  parameter int VW = 7,
  parameter logic [VW-1:0] VMASK = '1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr,
  input  logic [VW:0]   wdata,
  input  logic [VW-1:0] cnt,
  output logic [VW:0]   rdata,
  output logic          en,
  output logic          hit
);
  logic          en_q;
  logic [VW-1:0] val_q;

  // enable bit: cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) en_q <= 1'b0;
    else if (wr) en_q <= wdata[VW];
  end

  // value bits: no reset at all, survive every reset
  always_ff @(posedge clk) begin
    if (wr) val_q <= wdata[VW-1:0] & VMASK;
  end

  assign en    = en_q;
  assign rdata = {en_q, val_q & VMASK};
  assign hit   = !en_q || ((val_q & VMASK) == (cnt & VMASK));
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl (
  input  logic       clk,
  input  logic       por_n,
  input  logic       mrst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       match,
  output logic       match_q,
  output logic       flag,
  output logic       ie
);
  always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
    if (!por_n || !mrst_n) begin
      match_q <= 1'b0;
      flag    <= 1'b0;
      ie      <= 1'b0;
    end else begin
      match_q <= match;
      if (wr) ie <= wdata[1];
      if (match && !match_q) flag <= 1'b1;
      else if (wr && !wdata[0]) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [RW-1:0]    wdata,
  output logic [RW-1:0]    rdata,
  input  logic [NF*VW-1:0] cnt_bcd,
  output logic             irq
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NF);

  logic [NF*VW-1:0] cnt_q;
  logic [RW-1:0]    fld_rd [NF];
  logic [NF-1:0]    en_vec;
  logic [NF-1:0]    hit_vec;
  logic             match, match_q, flag, ie;
  logic             ctrl_wr;

  // registered sample of the counter chain
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_bcd;
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    rtc_alarm_field #(.VW(VW), .VMASK(field_mask(i))) u_fld (
      .clk   (clk),
      .por_n (por_n),
      .wr    (wr_en && (addr == AW'(i))),
      .wdata (wdata),
      .cnt   (cnt_q[i*VW +: VW]),
      .rdata (fld_rd[i]),
      .en    (en_vec[i]),
      .hit   (hit_vec[i])
    );
  end

  assign match   = (|en_vec) && (&hit_vec);
  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

  rtc_alarm_ctrl u_ctrl (
    .clk     (clk),
    .por_n   (por_n),
    .mrst_n  (mrst_n),
    .wr      (ctrl_wr),
    .wdata   (wdata[1:0]),
    .match   (match),
    .match_q (match_q),
    .flag    (flag),
    .ie      (ie)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NF; i++) begin
      if (addr == AW'(i)) rdata = fld_rd[i];
    end
    if (addr == CTRL_ADDR) rdata = {{(RW-2){1'b0}}, ie, flag};
  end

  assign irq = flag && ie;
endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
module rtc_alarm_cmp_chk #(
  parameter int NF = 6,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          por_n,
  input logic          mrst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          wd0,
  input logic [1:0]    rd_mon_rsvd,
  input logic [NF-1:0] en_vec,
  input logic          match,
  input logic          match_q,
  input logic          flag,
  input logic          ie,
  input logic          irq
);
  localparam logic [AW-1:0] CTRL_A = AW'(NF);
  localparam logic [AW-1:0] MON_A  = AW'(NF - 1);

  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    $rose(flag) |-> ($past(match) && !$past(match_q))); // R6

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    $rose(flag) |-> ($past(en_vec) != '0)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    (flag && !(wr_en && addr == CTRL_A && !wd0)) |=> flag); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    irq |-> ie); // R8

  AST_MON_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (addr == MON_A) |-> (rd_mon_rsvd == 2'b00)); // R2

  AST_EN_KEEP_MRST: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !wr_en) |=> $stable(en_vec)); // R9
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk #(.NF(NF), .AW(AW)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .mrst_n      (mrst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wd0         (wdata[0]),
  .rd_mon_rsvd (rdata[6:5]),
  .en_vec      (en_vec),
  .match       (match),
  .match_q     (match_q),
  .flag        (flag),
  .ie          (ie),
  .irq         (irq)
);

// File: tb/rtc_alarm_cmp_tb.sv
module rtc_alarm_cmp_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        mrst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [41:0] cnt_bcd = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_alarm_cmp u_dut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_bcd(cnt_bcd), .irq(irq)
  );

  // alarm values: sec 30, min 45, hour 12, weekday 3, date 31, month 12
  localparam logic [6:0] ALM  [6] = '{7'h30, 7'h45, 7'h12, 7'h03, 7'h31, 7'h12};
  localparam logic [6:0] MASK [6] = '{7'h7F, 7'h7F, 7'h3F, 7'h07, 7'h3F, 7'h1F};
  localparam logic [41:0] ALL_MATCH = {7'h12, 7'h31, 7'h03, 7'h12, 7'h45, 7'h30};

  // {expected flag, enable mask (bit i = field i), counters month..sec}
  localparam int NV = 8;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 6'b111111, 7'h12, 7'h31, 7'h03, 7'h12, 7'h45, 7'h30}, // R4 all match
    {1'b0, 6'b111111, 7'h12, 7'h31, 7'h03, 7'h12, 7'h45, 7'h31}, // R4 sec off
    {1'b1, 6'b000001, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h30}, // R3 sec only
    {1'b1, 6'b110000, 7'h12, 7'h31, 7'h05, 7'h07, 7'h11, 7'h59}, // R3 date+month
    {1'b0, 6'b110000, 7'h11, 7'h31, 7'h03, 7'h12, 7'h45, 7'h30}, // R3 month off
    {1'b0, 6'b000000, 7'h12, 7'h31, 7'h03, 7'h12, 7'h45, 7'h30}, // R5 none enabled
    {1'b1, 6'b001000, 7'h00, 7'h00, 7'h7B, 7'h00, 7'h00, 7'h00}, // R3 weekday bits masked
    {1'b1, 6'b000100, 7'h00, 7'h00, 7'h00, 7'h12, 7'h00, 7'h00}  // R3 hour only
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    cycles(1);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      bus_rd(3'(i), rd);
      chk(rd[7] === 1'b0, "R1 enable after power-on", rd, 8'h00);
    end
    bus_rd(3'd6, rd);
    chk(rd === 8'h00, "R1 control after power-on", rd, 8'h00);
    chk(irq === 1'b0, "R1 irq after power-on", {7'd0, irq}, 8'h00);

    // R2 writable bits and reserved bits
    for (int i = 0; i < 6; i++) begin
      bus_wr(3'(i), 8'hFF);
      bus_rd(3'(i), rd);
      chk(rd === {1'b1, MASK[i]}, "R2 readback of all-ones write", rd, {1'b1, MASK[i]});
    end
    bus_wr(3'd6, 8'hFF);
    bus_rd(3'd6, rd);
    chk(rd === 8'h02, "R7 write 1 to flag has no effect", rd, 8'h02);

    // table walk: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      cnt_bcd = '0;
      for (int i = 0; i < 6; i++) bus_wr(3'(i), {VEC[v][42 + i], ALM[i]});
      bus_wr(3'd6, 8'h02);
      cycles(2);
      cnt_bcd = VEC[v][41:0];
      cycles(3);
      bus_rd(3'd6, rd);
      chk(rd[0] === VEC[v][48], "R3/R4/R5 table flag", rd, {7'd0, VEC[v][48]});
      chk(irq === VEC[v][48], "R8 irq follows flag", {7'd0, irq}, {7'd0, VEC[v][48]});
    end

    // R4 latency: enable all, clear, then apply match
    cnt_bcd = '0;
    for (int i = 0; i < 6; i++) bus_wr(3'(i), {1'b1, ALM[i]});
    bus_wr(3'd6, 8'h02);
    cycles(2);
    addr = 3'd6;
    cnt_bcd = ALL_MATCH;
    @(posedge clk); #2;
    chk(rdata[0] === 1'b0, "R4 flag not set after first edge", rdata, 8'h02);
    @(posedge clk); #2;
    chk(rdata[0] === 1'b1, "R4 flag set after second edge", rdata, 8'h03);

    // R6 persisting match does not re-set after clear
    bus_wr(3'd6, 8'h02);
    cycles(4);
    bus_rd(3'd6, rd);
    chk(rd[0] === 1'b0, "R6 no re-set while match persists", rd, 8'h02);
    cnt_bcd = '0;
    cycles(2);
    cnt_bcd = ALL_MATCH;
    cycles(3);
    bus_rd(3'd6, rd);
    chk(rd[0] === 1'b1, "R6 set again after false-then-true", rd, 8'h03);

    // R7 set wins over clear in the same cycle
    cnt_bcd = '0;
    cycles(2);
    bus_wr(3'd6, 8'h02);
    cnt_bcd = ALL_MATCH;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd6; wdata = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    bus_rd(3'd6, rd);
    chk(rd[0] === 1'b1, "R7 set wins over clear", rd, 8'h03);
    bus_wr(3'd6, 8'h02);
    bus_rd(3'd6, rd);
    chk(rd[0] === 1'b0, "R7 write 0 clears flag", rd, 8'h02);

    // R8 flag recorded with interrupt disabled
    cnt_bcd = '0;
    bus_wr(3'd6, 8'h00);
    cycles(2);
    cnt_bcd = ALL_MATCH;
    cycles(3);
    bus_rd(3'd6, rd);
    chk(rd === 8'h01, "R8 flag recorded with ie 0", rd, 8'h01);
    chk(irq === 1'b0, "R8 irq masked", {7'd0, irq}, 8'h00);
    bus_wr(3'd6, 8'h03);
    #1;
    chk(irq === 1'b1, "R8 irq after enabling", {7'd0, irq}, 8'h01);

    // R9 manual reset
    cnt_bcd = '0;
    cycles(2);
    @(negedge clk); mrst_n = 1'b0;
    cycles(2);
    mrst_n = 1'b1;
    cycles(1);
    bus_rd(3'd6, rd);
    chk(rd === 8'h00, "R9 control cleared by manual reset", rd, 8'h00);
    chk(irq === 1'b0, "R9 irq cleared by manual reset", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 6; i++) begin
      bus_rd(3'(i), rd);
      chk(rd === {1'b1, ALM[i]}, "R9 alarm kept over manual reset", rd, {1'b1, ALM[i]});
    end

    // R10 power-on reset keeps values, clears enables
    @(negedge clk); por_n = 1'b0;
    cycles(2);
    por_n = 1'b1;
    cycles(1);
    for (int i = 0; i < 6; i++) begin
      bus_rd(3'(i), rd);
      chk(rd === {1'b0, ALM[i]}, "R10 value kept, enable cleared", rd, {1'b0, ALM[i]});
    end
    cnt_bcd = ALL_MATCH;
    cycles(3);
    bus_rd(3'd6, rd);
    chk(rd === 8'h00, "R10 no alarm after power-on reset", rd, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule